// File: doc/BRIEF.md
# Banked Level-Sensitive Interrupt Controller

This block gathers level-sensitive interrupt lines in groups of 32, called banks, and presents them to software through a small word-addressed register window. Each bank keeps a mask word that software changes only by writing to a set port or a clear port. Because of this, two agents can never overwrite each other's mask updates with a read-modify-write. A pending word shows which sources are both active and unmasked. Every bank's pending bits are merged into a single cascade interrupt output for a parent controller.

There is no priority encoder, no vector and no acknowledge. Software reads the pending words to find which line is active. It quiets a line either by clearing the cause at its source or by masking it. Every input line passes through a two-flop synchronizer before it reaches the status word. The bank count is a parameter and may be one or two.

Top module: `banked_irq_ctrl`

## Requirements
- R1: After reset every mask bit is 1 and every pending word reads 0. The cascade output `irq_out` is 0.
- R2: A write to the set port (bank offset 0x08) sets each mask bit whose data bit is 1. Bits written as 0 keep their value. A mask bit of 1 blocks its line.
- R3: A write to the clear port (bank offset 0x0C) clears each mask bit whose data bit is 1. Bits written as 0 keep their value.
- R4: The status word (bank offset 0x00) shows the inputs after two clock edges. An input change made before edge k is still invisible after edge k and becomes visible after edge k+1.
- R5: The pending word (bank offset 0x10) equals status AND NOT mask. It reads 0 when no unmasked source is active. The current mask reads at bank offset 0x04.
- R6: `irq_out` is the OR of all pending bits of all banks, registered once. It changes on the clock edge after the pending change.
- R7: Writes to offsets 0x00, 0x04 and 0x10 have no effect. The set and clear ports read back as 0.
- R8: Bank n occupies byte offsets n×0x20 to n×0x20+0x1F, and bank n holds lines 32n to 32n+31. An access to a bank index at or above the bank count reads 0, and a write to such an index changes no mask.
- R9: A pending bit stays set for as long as its input is held active and the line is unmasked. It falls once the input is released, with the same two-edge delay. No acknowledge is needed.
- R10: The bank count `NBANKS` is 1 or 2, which gives 32 or 64 lines.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| irq_in | input | NBANKS*32 | Level-sensitive interrupt sources, active high |
| bus_addr | input | ADDR_W | Byte address of the register access |
| bus_we | input | 1 | Write enable, sampled on the rising edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq_out | output | 1 | Merged cascade interrupt |

## Verification
The assertions assume that `bus_we` and `bus_addr` are stable around the rising edge. They also assume that only the set and clear ports may move a mask, so any mask change that appears without such a write is flagged. The bench drives every bus and interrupt input on the falling edge and samples half a cycle away from the rising edge. It holds `irq_in` low during reset and uses word-aligned addresses only.

// File: rtl/banked_irq_ctrl.sv
module banked_irq_ctrl #(
  parameter int NBANKS = 2,
  parameter int ADDR_W = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NBANKS*32-1:0]  irq_in,
  input  logic [ADDR_W-1:0]     bus_addr,
  input  logic                  bus_we,
  input  logic [31:0]           bus_wdata,
  output logic [31:0]           bus_rdata,
  output logic                  irq_out
);
  localparam int BW = ADDR_W - 5;
  localparam logic [4:0] OFF_RAW = 5'h00, OFF_MSK = 5'h04, OFF_SET = 5'h08,
                         OFF_CLR = 5'h0C, OFF_PND = 5'h10;

  logic [NBANKS-1:0][31:0] sync_a, raw, mask, pend;
  logic [NBANKS-1:0]       set_hit, clr_hit, bank_any;
  logic [BW-1:0]           bank_sel;
  logic [4:0]              reg_off;

  assign bank_sel = bus_addr[ADDR_W-1:5];
  assign reg_off  = bus_addr[4:0];

  initial begin
    a_r10_bank_count: assert (NBANKS == 1 || NBANKS == 2);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_a <= '0;
      raw    <= '0;
    end else begin
      sync_a <= irq_in;
      raw    <= sync_a;
    end
  end

  for (genvar b = 0; b < NBANKS; b++) begin : g_bank
    assign set_hit[b]  = bus_we && bank_sel == BW'(b) && reg_off == OFF_SET;
    assign clr_hit[b]  = bus_we && bank_sel == BW'(b) && reg_off == OFF_CLR;
    assign pend[b]     = raw[b] & ~mask[b];
    assign bank_any[b] = |pend[b];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          mask[b] <= '1;
      else if (set_hit[b]) mask[b] <= mask[b] | bus_wdata;
      else if (clr_hit[b]) mask[b] <= mask[b] & ~bus_wdata;
    end

    a_r2_set_port: assert property (@(posedge clk) disable iff (!rst_n)
      set_hit[b] |=> (mask[b] & $past(bus_wdata)) == $past(bus_wdata));
    a_r3_clear_port: assert property (@(posedge clk) disable iff (!rst_n)
      clr_hit[b] |=> (mask[b] & $past(bus_wdata)) == 32'h0);
    a_r7_mask_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !(set_hit[b] || clr_hit[b]) |=> $stable(mask[b]));
    a_r2_keep_zero_bits: assert property (@(posedge clk) disable iff (!rst_n)
      set_hit[b] |=> (mask[b] & ~$past(bus_wdata)) == ($past(mask[b]) & ~$past(bus_wdata)));
  end

  always_comb begin
    bus_rdata = '0;
    for (int b = 0; b < NBANKS; b++) begin
      if (bank_sel == BW'(b)) begin
        case (reg_off)
          OFF_RAW: bus_rdata = raw[b];
          OFF_MSK: bus_rdata = mask[b];
          OFF_PND: bus_rdata = pend[b];
          default: bus_rdata = '0;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_out <= 1'b0;
    else        irq_out <= |bank_any;
  end

  a_r6_cascade_rise: assert property (@(posedge clk) disable iff (!rst_n)
    (|bank_any) |=> irq_out);
  a_r6_cascade_fall: assert property (@(posedge clk) disable iff (!rst_n)
    !(|bank_any) |=> !irq_out);
endmodule

// File: tb/banked_irq_ctrl_tb.sv
module banked_irq_ctrl_tb;
  localparam int CLK_P = 10;
  localparam int NB = 2;
  localparam int AW = 8;

  logic clk = 0, rst_n = 0, bus_we = 0, irq_out;
  logic [NB*32-1:0] irq_in = '0;
  logic [AW-1:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  int n_chk = 0, n_bad = 0;

  banked_irq_ctrl #(.NBANKS(NB), .ADDR_W(AW)) u_dut (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .bus_addr(bus_addr),
    .bus_we(bus_we), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_out(irq_out));

  always #(CLK_P/2) clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_we = 1;
    @(posedge clk); #1; bus_we = 0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); bus_addr = a; #1; d = bus_rdata;
  endtask

  task automatic t_reset;
    logic [31:0] d;
    rd(8'h04, d); chk("R1 mask bank0", d, 32'hFFFF_FFFF);
    rd(8'h24, d); chk("R1 mask bank1", d, 32'hFFFF_FFFF);
    rd(8'h10, d); chk("R1 pend bank0", d, 32'h0);
    chk("R1 irq_out", {31'h0, irq_out}, 32'h0);
  endtask

  task automatic t_mask_ports;
    logic [31:0] d;
    wr(8'h0C, 32'h0000_00FF); rd(8'h04, d); chk("R3 clear", d, 32'hFFFF_FF00);
    wr(8'h08, 32'h0000_000F); rd(8'h04, d); chk("R2 set", d, 32'hFFFF_FF0F);
    wr(8'h0C, 32'h0);         rd(8'h04, d); chk("R3 zero keeps", d, 32'hFFFF_FF0F);
    wr(8'h08, 32'h0);         rd(8'h04, d); chk("R2 zero keeps", d, 32'hFFFF_FF0F);
    rd(8'h08, d); chk("R7 set port reads 0", d, 32'h0);
    rd(8'h0C, d); chk("R7 clear port reads 0", d, 32'h0);
  endtask

  task automatic t_sync_cascade;
    logic [31:0] d;
    @(negedge clk); irq_in[3] = 1'b1;
    @(posedge clk);
    rd(8'h00, d); chk("R4 not yet after one edge", d, 32'h0);
    rd(8'h00, d); chk("R4 visible after two edges", d, 32'h0000_0008);
    rd(8'h10, d); chk("R5 masked line not pending", d, 32'h0);
    chk("R6 masked gives no cascade", {31'h0, irq_out}, 32'h0);
    wr(8'h0C, 32'h0000_0008);
    chk("R6 cascade lags pending one edge", {31'h0, irq_out}, 32'h0);
    @(posedge clk); #1;
    chk("R6 cascade raised", {31'h0, irq_out}, 32'h1);
    rd(8'h10, d); chk("R5 pending", d, 32'h0000_0008);
  endtask

  task automatic t_level;
    logic [31:0] d;
    repeat (6) @(posedge clk);
    rd(8'h10, d); chk("R9 pending held", d, 32'h0000_0008);
    chk("R9 cascade held", {31'h0, irq_out}, 32'h1);
    @(negedge clk); irq_in[3] = 1'b0;
    @(posedge clk);
    rd(8'h10, d); chk("R9 still set one edge after release", d, 32'h0000_0008);
    rd(8'h10, d); chk("R9 cleared after release", d, 32'h0);
    @(posedge clk); #1;
    chk("R6 cascade dropped", {31'h0, irq_out}, 32'h0);
  endtask

  task automatic t_readonly;
    logic [31:0] d;
    wr(8'h04, 32'h0); wr(8'h00, 32'hFFFF_FFFF); wr(8'h10, 32'hFFFF_FFFF);
    rd(8'h04, d); chk("R7 mask write ignored", d, 32'hFFFF_FF07);
    rd(8'h00, d); chk("R7 status write ignored", d, 32'h0);
    rd(8'h10, d); chk("R7 pending write ignored", d, 32'h0);
  endtask

  task automatic t_banks;
    logic [31:0] d;
    wr(8'h2C, 32'h8000_0001);
    rd(8'h24, d); chk("R8 bank1 mask", d, 32'h7FFF_FFFE);
    rd(8'h04, d); chk("R8 bank0 untouched", d, 32'hFFFF_FF07);
    @(negedge clk); irq_in[32] = 1'b1; irq_in[63] = 1'b1; irq_in[1] = 1'b1;
    repeat (3) @(posedge clk);
    rd(8'h30, d); chk("R10 bank1 pending lines 32 and 63", d, 32'h8000_0001);
    rd(8'h20, d); chk("R8 bank1 status", d, 32'h8000_0001);
    rd(8'h10, d); chk("R8 bank0 pending masked", d, 32'h0);
    chk("R6 cascade from bank1", {31'h0, irq_out}, 32'h1);
    wr(8'h48, 32'hFFFF_FFFF); wr(8'h4C, 32'hFFFF_FFFF);
    rd(8'h44, d); chk("R8 out of range reads 0", d, 32'h0);
    rd(8'h50, d); chk("R8 out of range pending 0", d, 32'h0);
    rd(8'h24, d); chk("R8 bank1 mask after stray write", d, 32'h7FFF_FFFE);
    rd(8'h04, d); chk("R8 bank0 mask after stray write", d, 32'hFFFF_FF07);
    wr(8'h28, 32'h8000_0001);
    @(posedge clk); #1;
    chk("R2 mask stops cascade", {31'h0, irq_out}, 32'h0);
  endtask

  task automatic summary;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    t_reset;
    t_mask_ports;
    t_sync_cascade;
    t_level;
    t_readonly;
    t_banks;
    summary;
  end

  initial begin
    #(CLK_P * 20000);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    summary;
  end
endmodule